// File: doc/BRIEF.md
# Shadow/Highlight Colour Intensity Stage

This block sits in a pixel pipeline after the palette lookup. For every pixel it receives a 3-bit value for each of the red, green and blue channels and a 2-bit mode code that selects normal, shadow or highlight rendering. It turns each channel into a 4-bit intensity level on a scale from 0 to 14. It also produces an 8-bit value for each channel, for a sink that expects 8-bit digital video.

The three modes overlap on one shared scale. Normal uses the even levels. Shadow uses the lower half. Highlight uses the upper half, and its ends land on the top shadow level (7) and the top normal level (14). Because of this, normal and highlight output match at palette value 7, not at 8. The 8-bit value is the level times 17, so full normal white is 238 and never 255.

The stage has one pipeline register with valid/ready handshakes on both sides. A pixel is taken in on a clock edge where `in_valid` and `in_ready` are both high. It appears on the outputs after that edge with `out_valid` high. `in_ready` is high whenever the register is empty or the sink is taking the current pixel. While `out_valid` is high and `out_ready` is low, the outputs hold still and no new pixel is taken in.

Top module: `shl_intensity_stage`

## Requirements
- R1: Normal mode (mode code 2'b00) gives level = 2 × value for each channel, so values 0..7 map to the even levels 0..14.
- R2: Shadow mode (mode code 2'b01) gives level = value, so the levels run from 0 to 7 and bit 3 of the level is always 0.
- R3: Highlight mode (mode code 2'b10) gives level = value + 7. Value 0 gives 7, the same as the shadow maximum, and value 7 gives 14, the same as the normal maximum.
- R4: Mode code 2'b11 gives exactly the levels of normal mode.
- R5: Each 8-bit output equals its channel's level × 17. The upper and lower nibbles are both equal to the level, each normal step is 34, and the maximum is 238.
- R6: A pixel taken in on a clock edge is on the outputs with `out_valid` high right after that edge. When no pixel is taken in and the sink takes the current one, `out_valid` goes low.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs stay stable. `in_ready` equals `!out_valid || out_ready`.
- R8: While `rst_n` is low, `out_valid` is 0 and all level outputs are 0.
- R9: No output level ever goes above 14 in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel is present on the inputs |
| in_ready | output | 1 | The stage can take a pixel |
| in_mode | input | 2 | 00 normal, 01 shadow, 10 highlight, 11 normal |
| in_r | input | 3 | Red palette value |
| in_g | input | 3 | Green palette value |
| in_b | input | 3 | Blue palette value |
| out_valid | output | 1 | A result is present on the outputs |
| out_ready | input | 1 | The sink takes the result |
| out_r | output | 4 | Red intensity level, 0..14 |
| out_g | output | 4 | Green intensity level, 0..14 |
| out_b | output | 4 | Blue intensity level, 0..14 |
| out_r8 | output | 8 | Red level × 17 |
| out_g8 | output | 8 | Green level × 17 |
| out_b8 | output | 8 | Blue level × 17 |

## Verification
The assertions check these on every cycle:
- the ceiling of 14 on every level;
- the rule that the 8-bit nibbles match the level;
- the parity of normal levels, the range of shadow levels and the range of highlight levels one cycle after a pixel is taken in;
- the one-cycle latency and the hold rule under back-pressure.

Only the bench scenarios can show that each exact level is right. They sweep all eight values through every mode code with different values on each channel. This covers the shared endpoints at 7 and 14, the crossover at value 7, and the behaviour of the spare mode code.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int CODE_W = 3;
  localparam int LVL_W  = CODE_W + 1;
  localparam int EXP_W  = 2 * LVL_W;
  localparam int NCH    = 3;
  localparam int LVL_MAX = (1 << LVL_W) - 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_SHADOW = 2'b01,
    MODE_HILITE = 2'b10,
    MODE_SPARE  = 2'b11
  } shl_mode_e;
endpackage

// File: rtl/shl_level_map.sv
module shl_level_map
  import shl_pkg::*;
#(
  parameter int IN_W = CODE_W,
  localparam int OUT_W = IN_W + 1
) (
  input  logic [IN_W-1:0]  code,
  input  shl_mode_e        mode,
  output logic [OUT_W-1:0] level
);
  logic [OUT_W-1:0] lv_norm, lv_shad, lv_hili;

  always_comb begin
    lv_norm = {code, 1'b0};
    lv_shad = {1'b0, code};
    lv_hili = {1'b1, code} - OUT_W'(1);
    unique case (mode)
      MODE_SHADOW: level = lv_shad;
      MODE_HILITE: level = lv_hili;
      default:     level = lv_norm;
    endcase
  end
endmodule

// File: rtl/shl_expand.sv
module shl_expand #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 8,
  localparam int SCALE = ((1 << OUT_W) - 1) / ((1 << IN_W) - 1)
) (
  input  logic [IN_W-1:0]  level,
  output logic [OUT_W-1:0] wide
);
  always_comb wide = OUT_W'(level) * OUT_W'(SCALE);
endmodule

// File: rtl/shl_pipe_reg.sv
module shl_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_valid && s_ready) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);
  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && m_ready) |=> !m_valid);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

// File: rtl/shl_intensity_stage.sv
module shl_intensity_stage
  import shl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [CODE_W-1:0] in_r,
  input  logic [CODE_W-1:0] in_g,
  input  logic [CODE_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LVL_W-1:0]  out_r,
  output logic [LVL_W-1:0]  out_g,
  output logic [LVL_W-1:0]  out_b,
  output logic [EXP_W-1:0]  out_r8,
  output logic [EXP_W-1:0]  out_g8,
  output logic [EXP_W-1:0]  out_b8
);
  localparam int BEAT_W = NCH * (LVL_W + EXP_W);

  shl_mode_e                      mode_q;
  logic [NCH-1:0][CODE_W-1:0]     code_v;
  logic [NCH-1:0][LVL_W-1:0]      lvl_v;
  logic [NCH-1:0][EXP_W-1:0]      wide_v;
  logic [NCH-1:0][LVL_W-1:0]      lvl_o;
  logic [NCH-1:0][EXP_W-1:0]      wide_o;
  logic [BEAT_W-1:0]              beat_d, beat_q;

  assign mode_q = shl_mode_e'(in_mode);
  assign code_v = {in_b, in_g, in_r};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    shl_level_map #(.IN_W(CODE_W)) u_map (
      .code (code_v[c]),
      .mode (mode_q),
      .level(lvl_v[c])
    );
    shl_expand #(.IN_W(LVL_W), .OUT_W(EXP_W)) u_exp (
      .level(lvl_v[c]),
      .wide (wide_v[c])
    );
  end

  assign beat_d = {wide_v, lvl_v};

  shl_pipe_reg #(.W(BEAT_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (beat_d),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (beat_q)
  );

  assign {wide_o, lvl_o} = beat_q;
  assign out_r  = lvl_o[0];
  assign out_g  = lvl_o[1];
  assign out_b  = lvl_o[2];
  assign out_r8 = wide_o[0];
  assign out_g8 = wide_o[1];
  assign out_b8 = wide_o[2];

  assert_level_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_r <= LVL_W'(LVL_MAX) && out_g <= LVL_W'(LVL_MAX) && out_b <= LVL_W'(LVL_MAX)));
  assert_wide_nibbles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_r8 == {out_r, out_r} && out_g8 == {out_g, out_g} && out_b8 == {out_b, out_b}));
  assert_normal_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'b00) |=> (!out_r[0] && !out_g[0] && !out_b[0]));
  assert_shadow_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'b01) |=> (!out_r[LVL_W-1] && !out_g[LVL_W-1] && !out_b[LVL_W-1]));
  assert_hilite_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'b10) |=> (out_r >= LVL_W'(7) && out_g >= LVL_W'(7) && out_b >= LVL_W'(7)));
  assert_ready_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

// File: tb/tb_shl_intensity_stage.sv
`timescale 1ns/1ps
module tb_shl_intensity_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_mode = 2'b00;
  logic [2:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [3:0] out_r, out_g, out_b;
  logic [7:0] out_r8, out_g8, out_b8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shl_intensity_stage dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_r8(out_r8), .out_g8(out_g8), .out_b8(out_b8)
  );

  function automatic int ref_level(int code, int mode);
    case (mode)
      1: return code;
      2: return code + 7;
      default: return 2 * code;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pixel(string req, int r, int g, int b, int mode);
    check({req, " red"},   out_r, ref_level(r, mode));
    check({req, " green"}, out_g, ref_level(g, mode));
    check({req, " blue"},  out_b, ref_level(b, mode));
    check("R5 red8",   out_r8, 17 * ref_level(r, mode));
    check("R5 green8", out_g8, 17 * ref_level(g, mode));
    check("R5 blue8",  out_b8, 17 * ref_level(b, mode));
    check("R9 ceiling", int'(out_r <= 4'd14 && out_g <= 4'd14 && out_b <= 4'd14), 1);
  endtask

  task automatic send(int r, int g, int b, int mode);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_r = 3'(r); in_g = 3'(g); in_b = 3'(b); in_mode = 2'(mode);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R6 valid", out_valid, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 out_valid", out_valid, 0);
    check("R8 level", out_r + out_g + out_b, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep(int mode, string req);
    for (int v = 0; v < 8; v++) begin
      send(v, 7 - v, (v + 3) % 8, mode);
      check_pixel(req, v, 7 - v, (v + 3) % 8, mode);
    end
  endtask

  task automatic t_endpoints();
    send(7, 7, 7, 1);
    check("R3 shadow top", out_r, 7);
    send(0, 0, 0, 2);
    check("R3 hilite bottom equals shadow top", out_r, 7);
    send(7, 7, 7, 2);
    check("R3 hilite top", out_g, 14);
    send(7, 7, 7, 0);
    check("R3 normal top equals hilite top", out_b, 14);
    check("R5 white 238", out_b8, 238);
    send(1, 2, 3, 0);
    check("R5 step 34", out_g8 - out_r8, 34);
  endtask

  task automatic t_backpressure();
    send(1, 2, 3, 0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_r = 3'd6; in_g = 3'd5; in_b = 3'd4; in_mode = 2'b10;
    #1;
    check("R7 in_ready low", in_ready, 0);
    @(posedge clk); #1;
    check("R7 held valid", out_valid, 1);
    check_pixel("R7 held", 1, 2, 3, 0);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R7 in_ready high", in_ready, 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_pixel("R7 next", 6, 5, 4, 2);
    @(posedge clk); #1;
    check("R6 drain", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_sweep(0, "R1");
    t_sweep(1, "R2");
    t_sweep(2, "R3");
    t_sweep(3, "R4");
    t_endpoints();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule